// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block behaves like a small parallel NOR flash part on a synchronous memory bus. A byte-addressed array of `2**ADDR_W` bytes, divided into equal sectors of `2**SEC_W` bytes, holds the contents. The bus carries words of `BYTES` bytes (1, 2 or 4). Writes on the bus are not stored directly. They are decoded as command codes, and some codes start a multi-write sequence. A sequencer keeps track of the command mode, and that mode decides what a read returns: array data, the 8-bit status register, or a byte from a built-in query table.

The supported sequences are: return to array reading, status read, status clear, sector erase with confirm, lock/unlock with a second code, the query table, and buffered programming. A buffered program write carries a word count, then count+1 data words, then a confirm code. All operations finish in the cycle they are confirmed, so the ready flag is set at once.

Top module: `nflash_ctl`

## Requirements
- R1: After reset the block is in array mode with the status register equal to 0x00.
- R2: Writing 0x70 puts the block in status mode. Every read then returns the status register zero-extended to the bus width, with bit 7 as the ready flag. Later writes are decoded as fresh commands.
- R3: Writing 0x50 in array or status mode clears all status bits to 0x00 and returns to array mode.
- R4: Writing 0x20 and then 0xD0 fills every byte of the addressed sector with 0xFF and leaves other sectors intact. The sector base is the write address with its low SEC_W bits cleared. This sets status bit 7, and reads then return status.
- R5: If the write after 0x20 is anything other than 0xD0, the memory is not changed and the block returns to array mode.
- R6: Writing 0xE8 starts a buffered program. The next write's low byte is a count N. The next N+1 writes each store one bus word at their own address and set status bit 7. A following 0xD0 returns the block to array mode.
- R7: If the write after the N+1 data words is not 0xD0, the block still returns to array mode. The data words already stored are kept.
- R8: After 0x60, a write of 0xD0 or 0x01 sets status bit 7 and leaves reads returning status. Any other value returns the block to array mode.
- R9: Writing 0x98 enters query mode. A read uses the low address byte shifted right by log2(BYTES) as the table index. The table holds 0x51, 0x52, 0x59 at indices 0x10..0x12. An index at or beyond TBL_LEN reads as 0.
- R10: In query mode any write other than 0xFF is ignored, and 0xFF returns the block to array mode.
- R11: In array or status mode, a code other than 0x00, 0xFF, 0x20, 0x50, 0x60, 0x70, 0x98 or 0xE8 leaves the block in array mode with the memory unchanged.
- R12: A read presents data on `rdata` from the clock edge that samples `re`. Array words are little-endian: the byte at `addr` is placed in bits [7:0] and the byte at `addr+k` in bits [8k+7:8k], with the address wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8*BYTES | Write data; low byte is the command code |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 8*BYTES | Registered read data |

## Verification
Every sector is first erased so the array holds known values. The buffered program is then driven with a multi-word count and with a zero count, and is ended once by a valid confirm and once by a wrong confirm. An erase is aborted with a wrong second code, and another erase is confirmed at an address in the middle of a sector. Reading back both neighbouring sectors shows whether the sector base is masked correctly and whether the erase is limited to one sector. An unaligned array read separates little-endian assembly from big-endian. Query reads at entry indices and past the table end show whether the address shift and the bound check are right. Lock codes, stray writes in query mode and unknown codes are each followed by a read, which shows which mode the block ended in.

// File: rtl/nflash_pkg.sv
package nflash_pkg;
  typedef enum logic [2:0] {
    ST_ARRAY, ST_STATUS, ST_QUERY, ST_ERASE,
    ST_LOCK, ST_BCOUNT, ST_BDATA, ST_BCONF
  } mode_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_NOP     = 8'h00;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CLRST   = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_BUFPROG = 8'hE8;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LOCKSET = 8'h01;
endpackage

// File: rtl/nflash_mem.sv
module nflash_mem #(
  parameter int BYTES  = 2,
  parameter int ADDR_W = 8,
  parameter int SEC_W  = 6
) (
  input  logic                 clk,
  input  logic                 prog_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [8*BYTES-1:0]   wr_data,
  input  logic                 erase_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [8*BYTES-1:0]   rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_cell
    logic [ADDR_W-1:0] rel;
    logic [7:0]        cell_q;
    logic              in_word;
    logic              in_sector;
    assign rel       = ADDR_W'(j) - wr_addr;
    assign in_word   = (rel < ADDR_W'(BYTES));
    assign in_sector = (ADDR_W'(j) >> SEC_W) == (wr_addr >> SEC_W);
    // storage array carries no reset; contents are defined by erase/program
    always_ff @(posedge clk) begin
      if (erase_en && in_sector)
        cell_q <= 8'hFF;
      else if (prog_en && in_word)
        cell_q <= wr_data[8*rel[$clog2(BYTES+1)-1:0] +: 8];
    end
    assign cells[j] = cell_q;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign rd_word[8*i +: 8] = cells[rd_addr + ADDR_W'(i)];
  end
endmodule

// File: rtl/nflash_qrom.sv
module nflash_qrom #(
  parameter int BYTES   = 2,
  parameter int ADDR_W  = 8,
  parameter int SEC_W   = 6,
  parameter int TBL_LEN = 49
) (
  input  logic [7:0] idx,
  output logic [7:0] qbyte
);
  localparam int NSEC = 1 << (ADDR_W - SEC_W);
  localparam int SECB = 1 << SEC_W;

  always_comb begin
    qbyte = 8'h00;
    if (int'(idx) < TBL_LEN) begin
      case (idx)
        8'h10: qbyte = 8'h51;
        8'h11: qbyte = 8'h52;
        8'h12: qbyte = 8'h59;
        8'h13: qbyte = 8'h01;
        8'h15: qbyte = 8'h31;
        8'h1B: qbyte = 8'h45;
        8'h1C: qbyte = 8'h55;
        8'h27: qbyte = 8'(ADDR_W);
        8'h28: qbyte = 8'h02;
        8'h2A: qbyte = 8'(BYTES);
        8'h2C: qbyte = 8'h01;
        8'h2D: qbyte = 8'(NSEC - 1);
        8'h2E: qbyte = 8'((NSEC - 1) >> 8);
        8'h2F: qbyte = 8'(SECB >> 8);
        8'h30: qbyte = 8'(SECB >> 16);
        default: qbyte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nflash_seq.sv
module nflash_seq
  import nflash_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  wbyte,
  output mode_e       mode,
  output logic [7:0]  status,
  output logic        erase_go,
  output logic        prog_go
);
  mode_e            mode_q, mode_d;
  logic [7:0]       stat_q, stat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle_like;

  assign idle_like = (mode_q == ST_ARRAY) || (mode_q == ST_STATUS);

  always_comb begin
    mode_d   = mode_q;
    stat_d   = stat_q;
    cnt_d    = cnt_q;
    erase_go = 1'b0;
    prog_go  = 1'b0;
    if (we) begin
      case (mode_q)
        ST_ARRAY, ST_STATUS: begin
          case (wbyte)
            C_ERASE:   mode_d = ST_ERASE;
            C_CLRST:   begin stat_d = 8'h00; mode_d = ST_ARRAY; end
            C_LOCK:    mode_d = ST_LOCK;
            C_STATUS:  mode_d = ST_STATUS;
            C_QUERY:   mode_d = ST_QUERY;
            C_BUFPROG: mode_d = ST_BCOUNT;
            default:   mode_d = ST_ARRAY;
          endcase
        end
        ST_QUERY: if (wbyte == C_ARRAY) mode_d = ST_ARRAY;
        ST_ERASE: begin
          if (wbyte == C_CONFIRM) begin
            erase_go  = 1'b1;
            stat_d[7] = 1'b1;
            mode_d    = ST_STATUS;
          end else begin
            mode_d = ST_ARRAY;
          end
        end
        ST_LOCK: begin
          if (wbyte == C_CONFIRM || wbyte == C_LOCKSET) begin
            stat_d[7] = 1'b1;
            mode_d    = ST_STATUS;
          end else begin
            mode_d = ST_ARRAY;
          end
        end
        ST_BCOUNT: begin
          cnt_d  = CNT_W'(wbyte);
          mode_d = ST_BDATA;
        end
        ST_BDATA: begin
          prog_go   = 1'b1;
          stat_d[7] = 1'b1;
          if (cnt_q == '0) mode_d = ST_BCONF;
          else             cnt_d  = cnt_q - 1'b1;
        end
        ST_BCONF: begin
          if (wbyte == C_CONFIRM) stat_d[7] = 1'b1;
          mode_d = ST_ARRAY;
        end
        default: mode_d = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ST_ARRAY;
      stat_q <= 8'h00;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode   = mode_q;
  assign status = stat_q;

  assert_clear_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_like && we && wbyte == C_CLRST) |=> (status == 8'h00 && mode == ST_ARRAY));
  assert_erase_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (status[7] && mode == ST_STATUS));
  assert_erase_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_ERASE && we && wbyte != C_CONFIRM) |=> (mode == ST_ARRAY));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_BDATA && !we) |=> ($stable(cnt_q) && mode == ST_BDATA));
  assert_query_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_QUERY && we && wbyte != C_ARRAY) |=> (mode == ST_QUERY));
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !(idle_like && we && wbyte == C_CLRST)) |=> status[7]);
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, prog_go}));
endmodule

// File: rtl/nflash_ctl.sv
module nflash_ctl
  import nflash_pkg::*;
#(
  parameter int BYTES   = 2,
  parameter int ADDR_W  = 8,
  parameter int SEC_W   = 6,
  parameter int TBL_LEN = 49,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [8*BYTES-1:0] wdata,
  input  logic               we,
  input  logic               re,
  output logic [8*BYTES-1:0] rdata
);
  localparam int DW    = 8 * BYTES;
  localparam int SHIFT = (BYTES == 4) ? 2 : (BYTES == 2) ? 1 : 0;

  logic [1:0]    rst_sync;
  logic          rst_i;
  mode_e         mode;
  logic [7:0]    status;
  logic          erase_go, prog_go;
  logic [DW-1:0] arr_word, rd_sel, rdata_q;
  logic [7:0]    q_idx, q_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  nflash_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .we(we), .wbyte(wdata[7:0]),
    .mode(mode), .status(status), .erase_go(erase_go), .prog_go(prog_go)
  );

  nflash_mem #(.BYTES(BYTES), .ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_mem (
    .clk(clk), .prog_en(prog_go), .wr_addr(addr), .wr_data(wdata),
    .erase_en(erase_go), .rd_addr(addr), .rd_word(arr_word)
  );

  assign q_idx = addr[7:0] >> SHIFT;

  nflash_qrom #(.BYTES(BYTES), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .TBL_LEN(TBL_LEN)) u_qrom (
    .idx(q_idx), .qbyte(q_byte)
  );

  always_comb begin
    case (mode)
      ST_ARRAY: rd_sel = arr_word;
      ST_QUERY: rd_sel = DW'(q_byte);
      default:  rd_sel = DW'(status);
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)  rdata_q <= '0;
    else if (re) rdata_q <= rd_sel;
  end
  assign rdata = rdata_q;

  assert_reset_mode_R1: assert property (@(posedge clk)
    (!rst_i) |=> (mode == ST_ARRAY && status == 8'h00));
  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_i)
    (!re) |=> $stable(rdata));
endmodule

// File: tb/nflash_ctl_bench.sv
module nflash_ctl_bench;
  localparam int BYTES = 2;
  localparam int AW    = 8;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [DW-1:0] rdata;
  int            total = 0;
  int            bad = 0;
  int            cycles = 0;

  nflash_ctl u_nflash_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .re(re), .rdata(rdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired (all requirements) got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 rdata after reset", rdata, 16'h0000);
    wr(8'h00, 16'h0070);
    rd(8'h10, v);
    chk("R1 status zero after reset", v, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_erase_all();
    logic [DW-1:0] v;
    for (int s = 0; s < 4; s++) begin
      wr(8'(s * 64 + 3), 16'h0020);
      wr(8'(s * 64 + 3), 16'h00D0);
      rd(8'(s * 64), v);
      chk("R4 R2 status after erase", v, 16'h0080);
    end
    wr(8'h00, 16'h00FF);
    rd(8'h00, v);  chk("R4 erased word sector0", v, 16'hFFFF);
    rd(8'hFE, v);  chk("R4 erased word sector3", v, 16'hFFFF);
  endtask

  task automatic t_bufprog();
    logic [DW-1:0] v;
    wr(8'h40, 16'h00E8);
    rd(8'h40, v);  chk("R6 status read during count", v, 16'h0080);
    wr(8'h40, 16'h0002);
    wr(8'h40, 16'h1234);
    wr(8'h42, 16'hABCD);
    wr(8'h44, 16'h5A5A);
    wr(8'h40, 16'h00D0);
    rd(8'h42, v);  chk("R6 stored word 2", v, 16'hABCD);
    rd(8'h44, v);  chk("R6 stored word 3", v, 16'h5A5A);
    rd(8'h46, v);  chk("R6 word past count untouched", v, 16'hFFFF);
    rd(8'h41, v);  chk("R12 unaligned little-endian", v, 16'hCD12);
  endtask

  task automatic t_bad_confirm();
    logic [DW-1:0] v;
    wr(8'h80, 16'h00E8);
    wr(8'h80, 16'h0000);
    wr(8'h80, 16'h7788);
    wr(8'h80, 16'h0033);
    rd(8'h80, v);  chk("R7 data kept and array mode", v, 16'h7788);
  endtask

  task automatic t_erase_abort();
    logic [DW-1:0] v;
    wr(8'h40, 16'h0020);
    wr(8'h40, 16'h0077);
    rd(8'h40, v);  chk("R5 aborted erase leaves data", v, 16'h1234);
  endtask

  task automatic t_erase_sector();
    logic [DW-1:0] v;
    wr(8'h45, 16'h0020);
    wr(8'h45, 16'h00D0);
    rd(8'h45, v);  chk("R4 status mode after erase", v, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd(8'h40, v);  chk("R4 sector1 base erased", v, 16'hFFFF);
    rd(8'h7E, v);  chk("R4 sector1 top erased", v, 16'hFFFF);
    rd(8'h80, v);  chk("R4 neighbour sector kept", v, 16'h7788);
  endtask

  task automatic t_clear();
    logic [DW-1:0] v;
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h0050);
    rd(8'h80, v);  chk("R3 array mode after clear", v, 16'h7788);
    wr(8'h00, 16'h0070);
    rd(8'h00, v);  chk("R3 status cleared", v, 16'h0000);
    wr(8'h00, 16'h00FF);
  endtask

  task automatic t_lock();
    logic [DW-1:0] v;
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h00D0);
    rd(8'h80, v);  chk("R8 unlock sets ready", v, 16'h0080);
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h0001);
    rd(8'h80, v);  chk("R8 lock sets ready", v, 16'h0080);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h0042);
    rd(8'h80, v);  chk("R8 bad lock code to array", v, 16'h7788);
  endtask

  task automatic t_query();
    logic [DW-1:0] v;
    wr(8'h00, 16'h0098);
    rd(8'h20, v);  chk("R9 query Q", v, 16'h0051);
    rd(8'h22, v);  chk("R9 query R", v, 16'h0052);
    rd(8'h24, v);  chk("R9 query Y", v, 16'h0059);
    rd(8'h62, v);  chk("R9 index past table", v, 16'h0000);
    wr(8'h00, 16'h0012);
    rd(8'h20, v);  chk("R10 stray write keeps query", v, 16'h0051);
    wr(8'h00, 16'h00FF);
    rd(8'h80, v);  chk("R10 FF leaves query", v, 16'h7788);
  endtask

  task automatic t_unknown();
    logic [DW-1:0] v;
    wr(8'h80, 16'h003C);
    rd(8'h80, v);  chk("R11 unknown code stays array", v, 16'h7788);
    wr(8'h00, 16'h0070);
    wr(8'h80, 16'h00A5);
    rd(8'h80, v);  chk("R11 unknown code from status", v, 16'h7788);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_erase_all();
    t_bufprog();
    t_bad_confirm();
    t_erase_abort();
    t_erase_sector();
    t_clear();
    t_lock();
    t_query();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule